// File: doc/BRIEF.md
# Strobe/Data Inter-Chip Port Bus-State Monitor

This block is the downstream-facing (host or hub side) line controller for a two-wire inter-chip USB link built from a strobe line and a data line. While the port is powered but not enabled, it releases its drivers and turns on weak keepers that pull both wires to logic 0. Once software raises the port enable, it drives the IDLE level: strobe high and data low. It then watches the sampled wire levels for a peripheral announcing its presence.

A strobe-period tick paces the block. On each tick it classifies the sampled pair into a 3-bit line-state code. It also counts how long the connect level (strobe low, data high) has lasted. When that level has lasted at least two ticks and the lines then return to IDLE, it sets a sticky connect flag. The keeper enable follows the bus one strobe period late. It turns off one tick after a non-IDLE level is sampled, and turns back on one tick after IDLE is sampled again. Suspend, reset and resume timing, packet handling and pad electrics belong to other blocks.

Top module: `sdp_port_monitor`

## Requirements
- R1: After the active-low synchronous reset, strobeOut=0, dataOut=0, keeperEn=1, keeperPull=2'b00, lineState=0 (IDLE) and connectSeen=0.
- R2: In the cycle after portEn is sampled high, strobeOut=1, dataOut=0 and keeperPull=2'b10 (bit 1 pulls strobe, bit 0 pulls data).
- R3: On each periodTick while enabled, lineState takes the code of the sampled pair {strobeIn,dataIn}: 2'b10 gives 0 (IDLE/SUSPEND), 2'b01 gives 1 (CONNECT/RESUME), 2'b00 gives 2 (RESET), 2'b11 gives 3 (DATA_ACTIVE).
- R4: lineState changes only on a periodTick; input changes without a tick leave it unchanged.
- R5: connectSeen rises in the cycle after an IDLE tick that follows at least CONNECT_TICKS (default 2) consecutive connect-level ticks. It then stays high while portEn stays high.
- R6: A connect-level run shorter than CONNECT_TICKS, or a run broken by RESET or DATA_ACTIVE, does not set connectSeen. Counting restarts at zero after the break.
- R7: After a tick that samples any non-IDLE pair, keeperEn goes low at the following tick, one strobe period later.
- R8: After a tick that samples IDLE, keeperEn goes high again at the following tick.
- R9: When portEn is sampled low, strobeOut and keeperPull return to 0 in the next cycle. Within two cycles every output is back at its R1 value.
- R10: Ticks applied while portEn is low are ignored: lineState stays 0 and keeperEn stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| portEn | input | 1 | Port enable |
| strobeIn | input | 1 | Sampled strobe wire level |
| dataIn | input | 1 | Sampled data wire level |
| periodTick | input | 1 | One-cycle pulse per strobe period |
| strobeOut | output | 1 | Strobe drive value |
| dataOut | output | 1 | Data drive value |
| keeperEn | output | 1 | Weak keeper enable |
| keeperPull | output | 2 | Keeper pull level {strobe, data} |
| lineState | output | 3 | Decoded line-state code |
| connectSeen | output | 1 | Peripheral connect detected (sticky) |

## Verification
Every ordered pair of the four line levels is applied on consecutive ticks. This separates the classification codes from one another and shows the one-tick keeper lag in both directions, including non-IDLE to non-IDLE moves where the keeper must stay off. Connect-level runs of zero to four ticks, each followed by IDLE, locate the exact run-length threshold. Runs broken by RESET or DATA_ACTIVE confirm that the count restarts. Input changes without a tick, and ticks while disabled, show that the state moves only when it should.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  typedef enum logic [2:0] {
    LS_IDLE        = 3'd0,
    LS_CONN_RESUME = 3'd1,
    LS_RESET       = 3'd2,
    LS_DATA_ACTIVE = 3'd3
  } lineCode_e;

  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_WATCH  = 2'd1,
    ST_LINKED = 2'd2
  } portState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic active;  // port enabled and driving IDLE
    logic sample;  // strobe-period tick while active
  } ctrlStrobe_t;
endpackage

// File: rtl/sdp_ctrl.sv
module sdp_ctrl
  import sdp_pkg::*;
#(
  parameter int CONNECT_TICKS = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        portEn,
  input  logic        periodTick,
  input  lineCode_e   curCode,
  output ctrlStrobe_t strobes,
  output logic        connectSeen
);
  localparam int RUN_W = $clog2(CONNECT_TICKS + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(CONNECT_TICKS);

  portState_e       state;
  logic [RUN_W-1:0] runLen;

  always_ff @(posedge clk) begin
    if (!rstN || !portEn) begin
      state       <= ST_OFF;
      runLen      <= '0;
      connectSeen <= 1'b0;
    end else begin
      case (state)
        ST_OFF:   state <= ST_WATCH;
        ST_WATCH: begin
          if (periodTick) begin
            if (curCode == LS_CONN_RESUME) begin
              if (runLen != RUN_MAX) runLen <= runLen + 1'b1;
            end else if (curCode == LS_IDLE && runLen == RUN_MAX) begin
              connectSeen <= 1'b1;
              state       <= ST_LINKED;
            end else begin
              runLen <= '0;
            end
          end
        end
        default:  state <= ST_LINKED;
      endcase
    end
  end

  assign strobes.active = (state != ST_OFF);
  assign strobes.sample = (state != ST_OFF) && periodTick;
endmodule

// File: rtl/sdp_datapath.sv
module sdp_datapath
  import sdp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobes,
  input  logic        strobeIn,
  input  logic        dataIn,
  output lineCode_e   curCode,
  output logic [2:0]  lineState,
  output logic        keeperEn,
  output logic        strobeOut,
  output logic        dataOut,
  output logic [1:0]  keeperPull
);
  logic nonIdleSeen;

  always_comb begin
    case ({strobeIn, dataIn})
      2'b10:   curCode = LS_IDLE;
      2'b01:   curCode = LS_CONN_RESUME;
      2'b00:   curCode = LS_RESET;
      default: curCode = LS_DATA_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || !strobes.active) begin
      lineState   <= LS_IDLE;
      nonIdleSeen <= 1'b0;
      keeperEn    <= 1'b1;
    end else if (strobes.sample) begin
      lineState   <= curCode;
      nonIdleSeen <= (curCode != LS_IDLE);
      keeperEn    <= !nonIdleSeen;  // one strobe period behind the bus
    end
  end

  // IDLE drive is strobe high, data low; disabled port pulls both low
  assign strobeOut  = strobes.active;
  assign dataOut    = 1'b0;
  assign keeperPull = {strobes.active, 1'b0};
endmodule

// File: rtl/sdp_port_monitor.sv
module sdp_port_monitor
  import sdp_pkg::*;
#(
  parameter int CONNECT_TICKS = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       portEn,
  input  logic       strobeIn,
  input  logic       dataIn,
  input  logic       periodTick,
  output logic       strobeOut,
  output logic       dataOut,
  output logic       keeperEn,
  output logic [1:0] keeperPull,
  output logic [2:0] lineState,
  output logic       connectSeen
);
  ctrlStrobe_t ctlBus;
  lineCode_e   curCode;
  logic        linkActive;

  sdp_ctrl #(.CONNECT_TICKS(CONNECT_TICKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .portEn(portEn), .periodTick(periodTick),
    .curCode(curCode), .strobes(ctlBus), .connectSeen(connectSeen)
  );

  sdp_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(ctlBus), .strobeIn(strobeIn),
    .dataIn(dataIn), .curCode(curCode), .lineState(lineState),
    .keeperEn(keeperEn), .strobeOut(strobeOut), .dataOut(dataOut),
    .keeperPull(keeperPull)
  );

  assign linkActive = ctlBus.active;
endmodule

// File: rtl/sdp_monitor_checks.sv
module sdp_monitor_checks (
  input logic       clk,
  input logic       rstN,
  input logic       portEn,
  input logic       periodTick,
  input logic       linkActive,
  input logic       strobeOut,
  input logic       dataOut,
  input logic       keeperEn,
  input logic [1:0] keeperPull,
  input logic [2:0] lineState,
  input logic       connectSeen
);
  p_idle_drive_r2: assert property (@(posedge clk) disable iff (!rstN)
    portEn |=> (strobeOut && !dataOut && keeperPull == 2'b10));

  p_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    !portEn |=> (!strobeOut && !dataOut && keeperPull == 2'b00 && !connectSeen));

  p_hold_state_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!periodTick && portEn && linkActive) |=> $stable(lineState));

  p_connect_onset_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(connectSeen) |-> ($past(periodTick) && lineState == 3'd0));

  p_connect_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (connectSeen && portEn) |=> connectSeen);

  p_keeper_off_on_tick_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(keeperEn) |-> $past(periodTick));
endmodule

bind sdp_port_monitor sdp_monitor_checks u_chk (
  .clk(clk), .rstN(rstN), .portEn(portEn), .periodTick(periodTick),
  .linkActive(linkActive), .strobeOut(strobeOut), .dataOut(dataOut),
  .keeperEn(keeperEn), .keeperPull(keeperPull), .lineState(lineState),
  .connectSeen(connectSeen)
);

// File: tb/sim_sdp_port_monitor.sv
`timescale 1ns/1ps
module sim_sdp_port_monitor;
  logic clk = 1'b0;
  logic rstN, portEn, strobeIn, dataIn, periodTick;
  logic strobeOut, dataOut, keeperEn, connectSeen;
  logic [1:0] keeperPull;
  logic [2:0] lineState;

  int compared = 0;
  int mismatched = 0;

  // bench model state
  int expLine, expKeep, prevNonIdle, runCnt, expConn;

  always #2 clk = ~clk;

  sdp_port_monitor u0 (
    .clk(clk), .rstN(rstN), .portEn(portEn), .strobeIn(strobeIn),
    .dataIn(dataIn), .periodTick(periodTick), .strobeOut(strobeOut),
    .dataOut(dataOut), .keeperEn(keeperEn), .keeperPull(keeperPull),
    .lineState(lineState), .connectSeen(connectSeen)
  );

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  // level index: 0 IDLE {1,0}, 1 CONNECT {0,1}, 2 RESET {0,0}, 3 DATA {1,1}
  task automatic setLevel(input int lvl);
    case (lvl)
      0: begin strobeIn = 1'b1; dataIn = 1'b0; end
      1: begin strobeIn = 1'b0; dataIn = 1'b1; end
      2: begin strobeIn = 1'b0; dataIn = 1'b0; end
      default: begin strobeIn = 1'b1; dataIn = 1'b1; end
    endcase
  endtask

  task automatic tickLevel(input int lvl);
    @(negedge clk);
    setLevel(lvl);
    periodTick = 1'b1;
    @(negedge clk);
    periodTick = 1'b0;
    expLine = lvl;
    expKeep = (prevNonIdle != 0) ? 0 : 1;
    prevNonIdle = (lvl != 0) ? 1 : 0;
    if (expConn == 0) begin
      if (lvl == 1) runCnt = (runCnt < 2) ? runCnt + 1 : 2;
      else if (lvl == 0 && runCnt >= 2) expConn = 1;
      else runCnt = 0;
    end
    check("R3 lineState", int'(lineState), expLine);
    check("R7/R8 keeperEn", int'(keeperEn), expKeep);
    check("R5/R6 connectSeen", int'(connectSeen), expConn);
  endtask

  task automatic enablePort();
    @(negedge clk);
    portEn = 1'b1;
    @(negedge clk);
    expLine = 0; expKeep = 1; prevNonIdle = 0; runCnt = 0; expConn = 0;
    check("R2 strobeOut", int'(strobeOut), 1);
    check("R2 dataOut", int'(dataOut), 0);
    check("R2 keeperPull", int'(keeperPull), 2);
  endtask

  task automatic disablePort();
    @(negedge clk);
    portEn = 1'b0;
    @(negedge clk);
    check("R9 strobeOut", int'(strobeOut), 0);
    check("R9 keeperPull", int'(keeperPull), 0);
    check("R9 connectSeen", int'(connectSeen), 0);
    @(negedge clk);
    check("R9 keeperEn", int'(keeperEn), 1);
    check("R9 lineState", int'(lineState), 0);
  endtask

  initial begin
    #400000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    rstN = 1'b0; portEn = 1'b0; strobeIn = 1'b0; dataIn = 1'b0; periodTick = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 strobeOut", int'(strobeOut), 0);
    check("R1 dataOut", int'(dataOut), 0);
    check("R1 keeperEn", int'(keeperEn), 1);
    check("R1 keeperPull", int'(keeperPull), 0);
    check("R1 lineState", int'(lineState), 0);
    check("R1 connectSeen", int'(connectSeen), 0);

    // R10 ticks while disabled are ignored
    for (int k = 1; k < 4; k++) begin
      @(negedge clk); setLevel(k); periodTick = 1'b1;
      @(negedge clk); periodTick = 1'b0;
      @(negedge clk);
      check("R10 lineState", int'(lineState), 0);
      check("R10 keeperEn", int'(keeperEn), 1);
    end

    // R3 R7 R8 all ordered level pairs
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        enablePort();
        tickLevel(a);
        tickLevel(b);
        tickLevel(0);
        tickLevel(0);
        disablePort();
      end
    end

    // R5 R6 connect run-length sweep
    for (int run = 0; run < 5; run++) begin
      enablePort();
      tickLevel(0);
      for (int i = 0; i < run; i++) tickLevel(1);
      tickLevel(0);
      check(run >= 2 ? "R5 connect threshold" : "R6 short run", int'(connectSeen),
            run >= 2 ? 1 : 0);
      tickLevel(2);
      tickLevel(0);
      check("R5 sticky", int'(connectSeen), run >= 2 ? 1 : 0);
      disablePort();
    end

    // R6 broken runs
    for (int brk = 2; brk < 4; brk++) begin
      enablePort();
      tickLevel(1); tickLevel(brk); tickLevel(1); tickLevel(0);
      check("R6 broken run", int'(connectSeen), 0);
      tickLevel(1); tickLevel(1); tickLevel(brk); tickLevel(0);
      check("R6 broken after two", int'(connectSeen), 0);
      tickLevel(1); tickLevel(1); tickLevel(0);
      check("R5 after restart", int'(connectSeen), 1);
      disablePort();
    end

    // R4 no change without a tick
    enablePort();
    tickLevel(3);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); setLevel(k);
      @(negedge clk);
      check("R4 hold lineState", int'(lineState), 3);
    end
    disablePort();

    // R1 reset while enabled
    enablePort();
    tickLevel(1);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1; portEn = 1'b0;
    @(negedge clk);
    check("R1 reset lineState", int'(lineState), 0);
    check("R1 reset keeperEn", int'(keeperEn), 1);
    check("R1 reset strobeOut", int'(strobeOut), 0);

    summary();
    $finish;
  end
endmodule